// File: doc/BRIEF.md
# Dual Set-Associative Translation Buffer

This block turns virtual addresses into physical addresses using two translation buffers that work side by side. Each buffer holds 16 entries, arranged as 8 sets of 2 ways, and has its own page-size setting. The two settings may match or differ, so one buffer can map small code pages while the other maps large data pages. Every lookup probes both buffers at once. A hit returns the physical address and the caching policy of the page. It also reports which buffer supplied the translation.

Software loads entries through a write port that names the buffer, the set and the way. A global flush clears every entry in one cycle. A lookup that finds no entry raises a miss flag. A lookup that finds an entry whose permissions forbid the access raises a protection-fault flag. In both cases no translation is produced. The block does not walk page tables; resolving a miss is left to the software that reacts to the flag. Each lookup is resolved combinationally and captured in output registers, so its result appears one cycle after the request.

Top module: `dual_tlb`

## Requirements
- R1: While reset is low, and on the first cycle after it, every response output is zero. All 32 entries start invalid, so any lookup after reset misses.
- R2: A request accepted with req_valid high in one cycle gives rsp_valid high in the next cycle. When rsp_valid is low, rsp_hit, rsp_miss, rsp_fault, rsp_src, rsp_pol and rsp_pa are all zero. When rsp_valid is high, exactly one of rsp_hit, rsp_miss and rsp_fault is set.
- R3: The page-offset width of a buffer is 10 plus its 2-bit size code (00 = 1 KB, 01 = 2 KB, 10 = 4 KB, 11 = 8 KB). The set index is the 3 VA bits just above that offset. The tag is the VA shifted right by offset+3 and compared with the stored 19-bit tag.
- R4: On a hit, rsp_pa takes its bits at and above the offset from {ppn, 10'b0}, and its bits below the offset from the VA.
- R5: On a hit, rsp_pol carries the stored 2-bit caching policy unchanged (00 non-cached, 01 write-through, 10 copy-back, 11 reserved).
- R6: If both buffers hit, buffer 0 wins and rsp_src = 0. A hit in buffer 1 alone gives rsp_src = 1.
- R7: If neither buffer hits, rsp_miss is set and rsp_pa, rsp_pol and rsp_src are zero.
- R8: The stored permission bits are bit0 read, bit1 write and bit2 execute. req_acc 00 = read, 01 = write, 10 = execute and 11 = read each need the matching bit. If that bit is clear on the winning entry, rsp_fault is set, rsp_pa and rsp_pol are zero, and rsp_src names the winning buffer.
- R9: A write with wr_en high stores {wr_valid, wr_tag, wr_ppn, wr_perm, wr_pol} at buffer wr_tlb, set wr_set, way wr_way. A lookup made in the same cycle still sees the old contents. Lookups from the next cycle on see the new entry.
- R10: inv_all clears all 32 valid bits in one cycle. A write in the same cycle is discarded, so lookups in the following cycle miss.
- R11: A write with wr_valid = 0 removes only the addressed entry. The other buffer and the other way still translate.
- R12: If both ways of one set match, way 0 supplies the translation.
- R13: Each buffer indexes with its own size code. An entry in one buffer is not affected by the other buffer's size setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pgsz0 | input | 2 | Page-size code of buffer 0 |
| pgsz1 | input | 2 | Page-size code of buffer 1 |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind of the lookup |
| wr_en | input | 1 | Entry write strobe |
| wr_tlb | input | 1 | Buffer selected by the write |
| wr_set | input | 3 | Set selected by the write |
| wr_way | input | 1 | Way selected by the write |
| wr_valid | input | 1 | Valid bit written |
| wr_tag | input | 19 | Virtual tag written |
| wr_ppn | input | 22 | Physical page number written |
| wr_perm | input | 3 | Permission bits written (X,W,R) |
| wr_pol | input | 2 | Caching policy written |
| inv_all | input | 1 | Flush every entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation produced |
| rsp_miss | output | 1 | No buffer held the address |
| rsp_fault | output | 1 | Permission violation on a hit |
| rsp_src | output | 1 | Buffer that matched |
| rsp_pa | output | 32 | Physical address |
| rsp_pol | output | 2 | Caching policy of the page |

## Verification
On every cycle the assertions check the one-cycle latency, the zeroed outputs when idle, the single outcome flag per response and the blank miss response. They also check that buffer 0 wins over buffer 1 and that a lookup right after a flush misses. Only the bench's scenarios can show the address arithmetic for each size code. The same holds for the ordering between a write and a lookup in the same cycle, way-0 priority within a set, single-entry removal and the permission decoding per access kind. These are compared against a reference model of the entries kept in the bench.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  parameter int VA_W    = 32;
  parameter int PA_W    = 32;
  parameter int SETS    = 8;
  parameter int WAYS    = 2;
  parameter int NTLB    = 2;
  parameter int MIN_OFS = 10;

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TLB_W = (NTLB > 1) ? $clog2(NTLB) : 1;
  localparam int TAG_W = VA_W - MIN_OFS - IDX_W;
  localparam int PPN_W = PA_W - MIN_OFS;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [2:0]       perm;
    logic [1:0]       pol;
  } tlb_payload_t;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    tlb_payload_t     pay;
  } tlb_entry_t;

  // Width of the page offset for a given size code.
  function automatic int page_ofs(logic [1:0] code);
    return MIN_OFS + int'(code);
  endfunction

  function automatic logic [IDX_W-1:0] va_index(logic [VA_W-1:0] va, logic [1:0] code);
    return IDX_W'(va >> page_ofs(code));
  endfunction

  function automatic logic [TAG_W-1:0] va_tag(logic [VA_W-1:0] va, logic [1:0] code);
    return TAG_W'(va >> (page_ofs(code) + IDX_W));
  endfunction

  // Physical address: page frame from the entry, offset from the VA.
  function automatic logic [PA_W-1:0] make_pa(logic [VA_W-1:0] va,
                                              logic [PPN_W-1:0] ppn,
                                              logic [1:0] code);
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] mask;
    base = {ppn, {MIN_OFS{1'b0}}};
    mask = (PA_W'(1) << page_ofs(code)) - PA_W'(1);
    return (base & ~mask) | (PA_W'(va) & mask);
  endfunction

  function automatic logic perm_ok(logic [2:0] perm, logic [1:0] acc);
    case (acc)
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[2];
      default:   return perm[0];
    endcase
  endfunction
endpackage

// File: rtl/tlb_bank.sv
module tlb_bank
  import dtlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pgsz,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  tlb_entry_t       wr_entry,
  input  logic             inv_all,
  input  logic [VA_W-1:0]  look_va,
  output logic             hit,
  output tlb_payload_t     pay
);
  tlb_entry_t mem [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem[s][w] <= '0;
    end else if (inv_all) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem[s][w].valid <= 1'b0;
    end else if (wr_en) begin
      mem[wr_set][wr_way] <= wr_entry;
    end
  end

  logic [IDX_W-1:0] look_idx;
  logic [TAG_W-1:0] look_tag;
  logic [WAYS-1:0]  way_hit;

  assign look_idx = va_index(look_va, pgsz);
  assign look_tag = va_tag(look_va, pgsz);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_hit[w] = mem[look_idx][w].valid && (mem[look_idx][w].tag == look_tag);
  end

  // Lowest-numbered matching way supplies the payload.
  always_comb begin
    hit = |way_hit;
    pay = mem[look_idx][0].pay;
    for (int w = WAYS - 1; w >= 0; w--)
      if (way_hit[w]) pay = mem[look_idx][w].pay;
  end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import dtlb_pkg::*;
(
  input  logic [NTLB-1:0]                hit,
  input  tlb_payload_t [NTLB-1:0]        pay,
  input  logic [NTLB-1:0][1:0]           pgsz,
  input  logic [VA_W-1:0]                va,
  input  logic [1:0]                     acc,
  output logic                           o_hit,
  output logic                           o_miss,
  output logic                           o_fault,
  output logic [TLB_W-1:0]               o_src,
  output logic [PA_W-1:0]                o_pa,
  output logic [1:0]                     o_pol
);
  logic             found;
  logic [TLB_W-1:0] win;
  logic             allowed;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int t = NTLB - 1; t >= 0; t--)
      if (hit[t]) begin
        found = 1'b1;
        win   = TLB_W'(t);
      end
  end

  assign allowed = perm_ok(pay[win].perm, acc);
  assign o_hit   = found && allowed;
  assign o_fault = found && !allowed;
  assign o_miss  = !found;
  assign o_src   = found ? win : '0;
  assign o_pa    = o_hit ? make_pa(va, pay[win].ppn, pgsz[win]) : '0;
  assign o_pol   = o_hit ? pay[win].pol : 2'b00;
endmodule

// File: rtl/dual_tlb.sv
module dual_tlb
  import dtlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pgsz0,
  input  logic [1:0]       pgsz1,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_acc,
  input  logic             wr_en,
  input  logic [TLB_W-1:0] wr_tlb,
  input  logic [IDX_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [2:0]       wr_perm,
  input  logic [1:0]       wr_pol,
  input  logic             inv_all,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [TLB_W-1:0] rsp_src,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_pol
);
  logic [NTLB-1:0][1:0]    pgsz_vec;
  logic [NTLB-1:0]         bank_hit;
  tlb_payload_t [NTLB-1:0] bank_pay;
  tlb_entry_t              wr_entry;

  assign pgsz_vec = {pgsz1, pgsz0};
  assign wr_entry = '{valid: wr_valid, tag: wr_tag,
                      pay: '{ppn: wr_ppn, perm: wr_perm, pol: wr_pol}};

  for (genvar g = 0; g < NTLB; g++) begin : g_bank
    logic [1:0]   bank_pgsz;
    logic         bank_wr;
    tlb_payload_t pay_g;
    logic         hit_g;
    assign bank_pgsz = pgsz_vec[g];
    assign bank_wr   = wr_en && (wr_tlb == TLB_W'(g));
    tlb_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pgsz     (bank_pgsz),
      .wr_en    (bank_wr),
      .wr_set   (wr_set),
      .wr_way   (wr_way),
      .wr_entry (wr_entry),
      .inv_all  (inv_all),
      .look_va  (req_va),
      .hit      (hit_g),
      .pay      (pay_g)
    );
    assign bank_hit[g] = hit_g;
    assign bank_pay[g] = pay_g;
  end

  logic             nxt_hit;
  logic             nxt_miss;
  logic             nxt_fault;
  logic [TLB_W-1:0] nxt_src;
  logic [PA_W-1:0]  nxt_pa;
  logic [1:0]       nxt_pol;

  tlb_resolve u_resolve (
    .hit     (bank_hit),
    .pay     (bank_pay),
    .pgsz    (pgsz_vec),
    .va      (req_va),
    .acc     (req_acc),
    .o_hit   (nxt_hit),
    .o_miss  (nxt_miss),
    .o_fault (nxt_fault),
    .o_src   (nxt_src),
    .o_pa    (nxt_pa),
    .o_pol   (nxt_pol)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_src   <= '0;
      rsp_pa    <= '0;
      rsp_pol   <= 2'b00;
    end else begin
      rsp_valid <= 1'b1;
      rsp_hit   <= nxt_hit;
      rsp_miss  <= nxt_miss;
      rsp_fault <= nxt_fault;
      rsp_src   <= nxt_src;
      rsp_pa    <= nxt_pa;
      rsp_pol   <= nxt_pol;
    end
  end
endmodule

// File: rtl/dual_tlb_chk.sv
module dual_tlb_chk
  import dtlb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             inv_all,
  input logic [NTLB-1:0]  bank_hit,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_fault,
  input logic [TLB_W-1:0] rsp_src,
  input logic [PA_W-1:0]  rsp_pa,
  input logic [1:0]       rsp_pol
);
  // R2
  req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && rsp_pa == '0 && rsp_pol == 2'b00));

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  // R7
  miss_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == '0 && rsp_pol == 2'b00 && rsp_src == '0));

  // R6
  first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bank_hit[0]) |=> (!rsp_miss && rsp_src == '0));

  // R6
  second_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bank_hit[0] && bank_hit[1]) |=> (!rsp_miss && rsp_src == TLB_W'(1)));

  // R10
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_all) && req_valid) |=> rsp_miss);
endmodule

bind dual_tlb dual_tlb_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .inv_all   (inv_all),
  .bank_hit  (bank_hit),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_fault (rsp_fault),
  .rsp_src   (rsp_src),
  .rsp_pa    (rsp_pa),
  .rsp_pol   (rsp_pol)
);

// File: tb/tb_dual_tlb.sv
module tb_dual_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pgsz0 = 2'd0, pgsz1 = 2'd0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        wr_en = 1'b0, wr_tlb = 1'b0, wr_way = 1'b0, wr_valid = 1'b0;
  logic [2:0]  wr_set = '0;
  logic [18:0] wr_tag = '0;
  logic [21:0] wr_ppn = '0;
  logic [2:0]  wr_perm = '0;
  logic [1:0]  wr_pol = '0;
  logic        inv_all = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_src;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_pol;

  always #5 clk = ~clk;

  dual_tlb dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  bit          m_v    [2][8][2];
  bit [18:0]   m_tag  [2][8][2];
  bit [21:0]   m_ppn  [2][8][2];
  bit [2:0]    m_perm [2][8][2];
  bit [1:0]    m_pol  [2][8][2];

  function automatic longint unsigned pow2(int n);
    return longint'(1) << n;
  endfunction

  function automatic int ofs_of(int t);
    return 10 + ((t == 0) ? int'(pgsz0) : int'(pgsz1));
  endfunction

  // Packed response: {valid, hit, miss, fault, src, pol[1:0], pa[31:0]}
  function automatic logic [63:0] model_rsp(logic rv, logic [31:0] va, logic [1:0] acc);
    longint unsigned v = va;
    int ft, fw;
    bit found = 0;
    int need;
    longint unsigned pa;
    if (!rv) return 64'd0;
    for (int t = 1; t >= 0; t--) begin
      int o = ofs_of(t);
      int s = int'((v / pow2(o)) % 8);
      longint unsigned tg = v / pow2(o + 3);
      for (int w = 1; w >= 0; w--)
        if (m_v[t][s][w] && longint'(m_tag[t][s][w]) == tg) begin
          found = 1; ft = t; fw = w;
        end
      if (found && ft == t) begin
        // keep lowest match of this buffer; lower buffer overrides later
      end
    end
    if (!found) return {25'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 32'd0};
    begin
      int o = ofs_of(ft);
      int s = int'((v / pow2(o)) % 8);
      need = (acc == 2'b01) ? 1 : (acc == 2'b10) ? 2 : 0;
      if (!m_perm[ft][s][fw][need])
        return {25'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'(ft), 2'b00, 32'd0};
      pa = ((longint'(m_ppn[ft][s][fw]) * 1024) / pow2(o)) * pow2(o) + (v % pow2(o));
      return {25'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'(ft), m_pol[ft][s][fw], pa[31:0]};
    end
  endfunction

  function automatic logic [63:0] act_rsp();
    return {25'd0, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_src, rsp_pol, rsp_pa};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic [63:0] e;
    e = model_rsp(req_valid, req_va, req_acc);
    @(posedge clk); #1;
    check(tag, act_rsp(), e);
    if (inv_all) begin
      for (int t = 0; t < 2; t++)
        for (int s = 0; s < 8; s++)
          for (int w = 0; w < 2; w++) m_v[t][s][w] = 0;
    end else if (wr_en) begin
      m_v[wr_tlb][wr_set][wr_way]    = wr_valid;
      m_tag[wr_tlb][wr_set][wr_way]  = wr_tag;
      m_ppn[wr_tlb][wr_set][wr_way]  = wr_ppn;
      m_perm[wr_tlb][wr_set][wr_way] = wr_perm;
      m_pol[wr_tlb][wr_set][wr_way]  = wr_pol;
    end
    wr_en = 0; inv_all = 0; req_valid = 0;
  endtask

  task automatic set_wr(int t, logic [31:0] va, int w, bit vld,
                        logic [21:0] ppn, logic [2:0] perm, logic [1:0] pol);
    longint unsigned v = va;
    int o = ofs_of(t);
    wr_en = 1; wr_tlb = 1'(t); wr_way = 1'(w); wr_valid = vld;
    wr_set = 3'((v / pow2(o)) % 8);
    wr_tag = 19'(v / pow2(o + 3));
    wr_ppn = ppn; wr_perm = perm; wr_pol = pol;
  endtask

  task automatic set_look(logic [31:0] va, logic [1:0] acc);
    req_valid = 1; req_va = va; req_acc = acc;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  logic [31:0] pool [8];

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (2) @(posedge clk);
    #1 check("R1 reset outputs", act_rsp(), 64'd0);
    @(negedge clk); rst_n = 1;
    set_look(32'h1234_5678, 2'b00); tick("R1 empty after reset");

    // R9: write and same-cycle lookup sees old, next cycle sees new
    pgsz0 = 2'd0; pgsz1 = 2'd3;
    set_wr(0, 32'h0040_1C00, 0, 1, 22'h2AB, 3'b111, 2'b10);
    set_look(32'h0040_1C55, 2'b00); tick("R9 same-cycle old content");
    set_look(32'h0040_1C55, 2'b00); tick("R9 R4 R5 hit after write");
    set_look(32'h0040_1FFF, 2'b01); tick("R4 offset top of 1KB page");
    set_look(32'h0040_1800, 2'b00); tick("R3 neighbour set misses");

    // R13: buffer 1 with 8 KB pages
    set_wr(1, 32'h8000_6000, 1, 1, 22'h155, 3'b101, 2'b01);
    tick("R9 write buffer1");
    set_look(32'h8000_7ABC, 2'b10); tick("R13 8KB page hit in buffer1");
    set_look(32'h8000_6004, 2'b00); tick("R3 index ignores low bits under 8KB");
    pgsz0 = 2'd2;
    set_look(32'h8000_7ABC, 2'b00); tick("R13 buffer0 size does not touch buffer1");
    pgsz0 = 2'd0;

    // R6: both buffers hit the same VA
    set_wr(1, 32'h0040_1C00, 0, 1, 22'h3F0, 3'b111, 2'b00); tick("R9 write dup");
    set_look(32'h0040_1C20, 2'b00); tick("R6 buffer0 wins");
    set_wr(0, 32'h0040_1C00, 0, 0, 22'h0, 3'b000, 2'b00); tick("R11 drop buffer0 entry");
    set_look(32'h0040_1C20, 2'b00); tick("R11 R6 buffer1 translates");

    // R12: both ways in one set match
    set_wr(0, 32'h0100_0400, 0, 1, 22'h111, 3'b111, 2'b11); tick("R9 way0");
    set_wr(0, 32'h0100_0400, 1, 1, 22'h222, 3'b111, 2'b01); tick("R9 way1");
    set_look(32'h0100_0410, 2'b00); tick("R12 way0 wins");
    set_wr(0, 32'h0100_0400, 0, 0, 22'h0, 3'b000, 2'b00); tick("R11 drop way0");
    set_look(32'h0100_0410, 2'b00); tick("R11 R12 way1 remains");

    // R8: permission decoding
    set_wr(0, 32'h0200_0000, 0, 1, 22'h0AA, 3'b001, 2'b10); tick("R9 read-only entry");
    set_look(32'h0200_0008, 2'b01); tick("R8 write faults");
    set_look(32'h0200_0008, 2'b10); tick("R8 exec faults");
    set_look(32'h0200_0008, 2'b00); tick("R8 read hits");
    set_look(32'h0200_0008, 2'b11); tick("R8 kind 3 acts as read");

    // R10: flush with simultaneous write
    inv_all = 1;
    set_wr(0, 32'h0300_0000, 0, 1, 22'h077, 3'b111, 2'b00);
    tick("R10 flush cycle");
    set_look(32'h0300_0000, 2'b00); tick("R10 write discarded");
    set_look(32'h8000_7ABC, 2'b00); tick("R10 old entry flushed");
    tick("R2 idle cycle");

    // Random phases
    for (int ph = 0; ph < 4; ph++) begin
      pgsz0 = 2'($urandom_range(0, 3));
      pgsz1 = 2'($urandom_range(0, 3));
      inv_all = 1; tick("R10 phase flush");
      for (int i = 0; i < 8; i++) pool[i] = $urandom;
      for (int c = 0; c < 500; c++) begin
        int r = $urandom_range(0, 99);
        if (r < 30)
          set_wr($urandom_range(0, 1), pool[$urandom_range(0, 7)], $urandom_range(0, 1),
                 ($urandom_range(0, 7) != 0), 22'($urandom), 3'($urandom), 2'($urandom));
        if (r >= 20 && r < 90)
          set_look(pool[$urandom_range(0, 7)] ^ 32'($urandom_range(0, 1023)),
                   2'($urandom));
        else if (r >= 90)
          set_look($urandom, 2'($urandom));
        tick("R3 random lookup");
      end
    end
    summary();
  end
endmodule